// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one channel of a general-purpose timer. A counter counts down by one on each count-enable tick while the channel runs. When a tick arrives while the counter already holds zero, the channel records an underflow. On that underflow it reloads the counter from a software-programmed reload value, gives a single-cycle underflow pulse, and sets a sticky interrupt flag. In repeat mode the channel then keeps running, so the pulse can serve as a periodic trigger. In one-shot mode the channel clears its own run bit right after the reload, which gives one timed wait per start.

Software reaches the channel through four 16-bit registers with a synchronous write strobe and a registered read. Read data appears on `rdata_o` in the cycle after the read strobe. Software can load the counter from the reload value at any time with a write-one preset command. The interrupt flag is cleared by writing one to it, and a separate enable bit gates it onto the interrupt request output. The count-enable tick stands in for a prescaled clock.

Top module: `dcnt_timer`

## Requirements
- R1: After reset, all four registers read 0, and `underflow_o` and `irq_o` are 0.
- R2: The counter decrements by one on a clock edge where `tick_i` is high and the run bit is set. If the run bit is clear, ticks are ignored and the counter keeps its value.
- R3: A tick while running with the counter at 0 is an underflow. On that edge the counter is loaded with the reload value, and `underflow_o` is high for exactly the following cycle.
- R4: In repeat mode (mode bit = 0) with a tick every cycle and reload value N, underflow pulses arrive every N+1 cycles and the channel keeps running.
- R5: In one-shot mode (mode bit = 1), the first underflow reloads the counter and clears the run bit, so exactly one pulse follows each start. The mode bit keeps its value.
- R6: Writing 1 to the preset bit (control bit 1) loads the counter with the reload value. It overrides a tick in the same cycle, and no underflow results. Writing 0 there does nothing, and the bit reads back as 0.
- R7: The interrupt flag (interrupt register bit 0) is set on every underflow and cleared by writing 1 to that bit. Writing 0 to the bit leaves it unchanged. An underflow in the same cycle as a clear leaves the flag set.
- R8: `irq_o` is high exactly when both the flag and the enable (interrupt register bit 8) are 1.
- R9: The register addresses are 0 for reload (read/write), 1 for counter (read-only, writes ignored), 2 for control, and 3 for interrupt. The control register has run at bit 0, preset at bit 1 and mode at bit 4. All other control and interrupt bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| underflow_o | output | 1 | One-cycle underflow pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle. It checks that each underflow pulse comes from a running tick at a zero count, and that a stopped and unpreset counter holds its value. It also checks that a preset loads the reload value without a pulse, that a one-shot underflow drops the run bit, and that every pulse or interrupt request is backed by a set flag. The bench covers what only a sequence of operations can show: the pulse spacing for each small reload value, the exact count after various tick densities, the single pulse per one-shot start, and the set-beats-clear race on the flag. It also checks the register layout as seen through reads.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_INTR   = 2'd3
    } reg_sel_e;

    localparam int CTL_RUN_BIT    = 0;
    localparam int CTL_PRESET_BIT = 1;
    localparam int CTL_MODE_BIT   = 4;
    localparam int INT_FLAG_BIT   = 0;
    localparam int INT_EN_BIT     = 8;
endpackage

// File: rtl/dtmr_count.sv
module dtmr_count #(
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          mode_i,
    input  logic          preset_i,
    input  logic [DW-1:0] reload_i,
    output logic [DW-1:0] cnt_o,
    output logic          uf_evt_o,
    output logic          uf_o,
    output logic          os_stop_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          uf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    evt;

    always_comb begin
        st_d    = st_q;
        st_d.uf = 1'b0;
        evt     = 1'b0;
        if (preset_i) begin
            st_d.cnt = reload_i;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload_i;
                st_d.uf  = 1'b1;
                evt      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign uf_o      = st_q.uf;
    assign uf_evt_o  = evt;
    assign os_stop_o = evt & mode_i;
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq
    import dtmr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          int_wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          uf_evt_i,
    output logic          ie_o,
    output logic          flag_o,
    output logic          irq_o
);
    typedef struct packed {
        logic ie;
        logic flag;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (int_wr_i) begin
            st_d.ie = wdata_i[INT_EN_BIT];
            if (wdata_i[INT_FLAG_BIT]) st_d.flag = 1'b0;
        end
        if (uf_evt_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ie_o   = st_q.ie;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & st_q.ie;
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
    import dtmr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] cnt_i,
    input  logic          ie_i,
    input  logic          flag_i,
    input  logic          os_stop_i,
    output logic [DW-1:0] reload_o,
    output logic          run_o,
    output logic          mode_o,
    output logic          preset_o,
    output logic          int_wr_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [DW-1:0] reload;
        logic          run;
        logic          mode;
        logic [DW-1:0] rdata;
    } reg_st_t;

    reg_st_t       st_d, st_q;
    reg_sel_e      sel;
    logic          wr_reload, wr_ctrl, wr_intr;
    logic [DW-1:0] ctrl_word, intr_word;

    assign sel       = reg_sel_e'(addr_i);
    assign wr_reload = wr_en_i && (sel == SEL_RELOAD);
    assign wr_ctrl   = wr_en_i && (sel == SEL_CTRL);
    assign wr_intr   = wr_en_i && (sel == SEL_INTR);

    always_comb begin
        ctrl_word               = '0;
        ctrl_word[CTL_RUN_BIT]  = st_q.run;
        ctrl_word[CTL_MODE_BIT] = st_q.mode;
        intr_word               = '0;
        intr_word[INT_FLAG_BIT] = flag_i;
        intr_word[INT_EN_BIT]   = ie_i;
    end

    always_comb begin
        st_d = st_q;
        if (wr_reload) st_d.reload = wdata_i;
        if (os_stop_i) st_d.run = 1'b0;
        if (wr_ctrl) begin
            st_d.run  = wdata_i[CTL_RUN_BIT];
            st_d.mode = wdata_i[CTL_MODE_BIT];
        end
        if (rd_en_i) begin
            unique case (sel)
                SEL_RELOAD: st_d.rdata = st_q.reload;
                SEL_COUNT:  st_d.rdata = cnt_i;
                SEL_CTRL:   st_d.rdata = ctrl_word;
                SEL_INTR:   st_d.rdata = intr_word;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reload_o = st_q.reload;
    assign run_o    = st_q.run;
    assign mode_o   = st_q.mode;
    assign preset_o = wr_ctrl & wdata_i[CTL_PRESET_BIT];
    assign int_wr_o = wr_intr;
    assign rdata_o  = st_q.rdata;
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer #(
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          underflow_o,
    output logic          irq_o
);
    logic [DW-1:0] reload_w, cnt_w;
    logic          run_w, mode_w, preset_w, int_wr_w;
    logic          uf_evt_w, os_stop_w, ie_w, flag_w;

    dtmr_regs #(.DW(DW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .cnt_i     (cnt_w),
        .ie_i      (ie_w),
        .flag_i    (flag_w),
        .os_stop_i (os_stop_w),
        .reload_o  (reload_w),
        .run_o     (run_w),
        .mode_o    (mode_w),
        .preset_o  (preset_w),
        .int_wr_o  (int_wr_w),
        .rdata_o   (rdata_o)
    );

    dtmr_count #(.DW(DW)) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .run_i     (run_w),
        .mode_i    (mode_w),
        .preset_i  (preset_w),
        .reload_i  (reload_w),
        .cnt_o     (cnt_w),
        .uf_evt_o  (uf_evt_w),
        .uf_o      (underflow_o),
        .os_stop_o (os_stop_w)
    );

    dtmr_irq #(.DW(DW)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .int_wr_i (int_wr_w),
        .wdata_i  (wdata_i),
        .uf_evt_i (uf_evt_w),
        .ie_o     (ie_w),
        .flag_o   (flag_w),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/dcnt_timer_chk.sv
module dcnt_timer_chk #(
    parameter int DW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tick_i,
    input logic          wr_en_i,
    input logic [1:0]    addr_i,
    input logic          underflow_o,
    input logic          irq_o,
    input logic          run_w,
    input logic          mode_w,
    input logic          preset_w,
    input logic          flag_w,
    input logic [DW-1:0] cnt_w,
    input logic [DW-1:0] reload_w
);
    // R3
    uf_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underflow_o |-> ($past(tick_i) && $past(run_w) && ($past(cnt_w) == '0)));

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!run_w) && $past(!preset_w)) |-> (cnt_w == $past(cnt_w)));

    // R6
    preset_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(preset_w) |-> ((cnt_w == $past(reload_w)) && !underflow_o));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (underflow_o && mode_w && !$past(wr_en_i && (addr_i == 2'd2))) |-> !run_w);

    // R7
    uf_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underflow_o |-> flag_w);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> flag_w);
endmodule

bind dcnt_timer dcnt_timer_chk #(.DW(DW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .underflow_o (underflow_o),
    .irq_o       (irq_o),
    .run_w       (run_w),
    .mode_w      (mode_w),
    .preset_w    (preset_w),
    .flag_w      (flag_w),
    .cnt_w       (cnt_w),
    .reload_w    (reload_w)
);

// File: tb/dcnt_timer_bench.sv
module dcnt_timer_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [15:0] wdata_i = 16'h0;
    logic [15:0] rdata_o;
    logic        underflow_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    dcnt_timer #(.DW(16)) u_dcnt_timer (.*);

    always #2.5 clk_i = ~clk_i;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk_i);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk_i);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    always @(posedge clk_i) begin
        cyc <= cyc + 1;
        if (cyc == 200000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected below 200000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R1 reset state
        check("R1 irq", {15'd0, irq_o}, 16'd0);
        check("R1 underflow", {15'd0, underflow_o}, 16'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 16'h0000);
        end

        // R4 R3 repeat-mode spacing sweep
        for (int r = 0; r < 6; r++) begin
            int last, pulses;
            last = -1; pulses = 0;
            wr(2'd0, 16'(r));
            wr(2'd2, 16'h0002);
            wr(2'd2, 16'h0001);
            tick_i = 1'b1;
            for (int c = 0; c < 4 * (r + 1) + 2; c++) begin
                @(negedge clk_i);
                if (underflow_o) begin
                    if (last >= 0) check("R4 gap", 16'(c - last), 16'(r + 1));
                    last = c; pulses++;
                end
            end
            tick_i = 1'b0;
            check("R4 pulses>=3", 16'(pulses >= 3), 16'd1);
            wr(2'd2, 16'h0000);
        end

        // R2 ticks ignored while stopped
        rd(2'd1, v);
        tick_i = 1'b1;
        repeat (5) @(negedge clk_i);
        tick_i = 1'b0;
        rd(2'd1, v2);
        check("R2 stopped hold", v2, v);

        // R2 decrement under varied tick densities
        for (int s = 1; s < 4; s++) begin
            int n;
            n = 0;
            wr(2'd0, 16'd100);
            wr(2'd2, 16'h0002);
            wr(2'd2, 16'h0001);
            for (int i = 0; i < 12; i++) begin
                @(negedge clk_i);
                tick_i = (i % s == 0);
                if (i % s == 0) n++;
            end
            @(negedge clk_i);
            tick_i = 1'b0;
            wr(2'd2, 16'h0000);
            rd(2'd1, v);
            check("R2 count", v, 16'(100 - n));
        end

        // R5 R7 R8 one-shot sweep
        for (int r = 0; r < 5; r++) begin
            int pulses;
            pulses = 0;
            wr(2'd3, 16'h0001);
            wr(2'd0, 16'(r));
            wr(2'd2, 16'h0002);
            wr(2'd2, 16'h0011);
            tick_i = 1'b1;
            for (int c = 0; c < r + 6; c++) begin
                @(negedge clk_i);
                if (underflow_o) pulses++;
            end
            tick_i = 1'b0;
            check("R5 single pulse", 16'(pulses), 16'd1);
            rd(2'd1, v);
            check("R3 R5 reloaded", v, 16'(r));
            rd(2'd2, v);
            check("R5 run cleared", v, 16'h0010);
            rd(2'd3, v);
            check("R7 flag set", v, 16'h0001);
            check("R8 irq masked", {15'd0, irq_o}, 16'd0);
        end
        wr(2'd3, 16'h0100);
        check("R8 irq enabled", {15'd0, irq_o}, 16'd1);
        rd(2'd3, v);
        check("R7 write0 ignored", v, 16'h0101);
        wr(2'd3, 16'h0101);
        check("R8 irq after clear", {15'd0, irq_o}, 16'd0);
        rd(2'd3, v);
        check("R7 cleared", v, 16'h0100);

        // R6 preset beats tick; preset reads 0; write 0 no effect
        wr(2'd0, 16'd40);
        wr(2'd2, 16'h0001);
        @(negedge clk_i);
        tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 16'h0003;
        @(negedge clk_i);
        tick_i = 1'b0; wr_en_i = 1'b0;
        check("R6 no pulse", {15'd0, underflow_o}, 16'd0);
        wr(2'd2, 16'h0000);
        rd(2'd1, v);
        check("R6 preset value", v, 16'd40);
        rd(2'd2, v);
        check("R6 preset reads 0", v, 16'h0000);
        wr(2'd0, 16'd7);
        wr(2'd2, 16'h0000);
        rd(2'd1, v);
        check("R6 write0 no effect", v, 16'd40);

        // R7 set wins over clear
        wr(2'd0, 16'd0);
        wr(2'd2, 16'h0002);
        wr(2'd2, 16'h0001);
        @(negedge clk_i);
        tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd3; wdata_i = 16'h0101;
        @(negedge clk_i);
        tick_i = 1'b0; wr_en_i = 1'b0;
        check("R3 pulse", {15'd0, underflow_o}, 16'd1);
        check("R8 irq", {15'd0, irq_o}, 16'd1);
        @(negedge clk_i);
        check("R3 pulse one cycle", {15'd0, underflow_o}, 16'd0);
        wr(2'd2, 16'h0000);
        rd(2'd3, v);
        check("R7 set wins", v, 16'h0101);

        // R9 layout and read-only counter
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v);
        check("R9 intr reserved", v, 16'h0100);
        wr(2'd3, 16'h0000);
        wr(2'd2, 16'hFFE8);
        rd(2'd2, v);
        check("R9 ctrl reserved", v, 16'h0000);
        rd(2'd1, v);
        wr(2'd1, 16'h1234);
        rd(2'd1, v2);
        check("R9 counter read-only", v2, v);
        rd(2'd0, v);
        check("R9 reload readback", v, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule